// File: doc/BRIEF.md
# Virtual address region classifier

This block sits at the front of an address translation path. It takes a 64-bit virtual address and decides which of two translation regions covers it. The bottom region starts at address zero and grows upward. The top region ends at the all-ones address and grows downward. A hit in the bottom region selects the lower table base, and a hit in the top region selects the upper table base. An address in the gap between the two regions raises a translation fault.

Each region has its own size field, which gives the number of address bits the region covers. The top region exists only at the two least privileged levels. The block also produces the non-secure attribute for the later physical access. The result is registered, so it appears one clock after the inputs are presented.

Top module: `vaddr_region_cls`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `sel_lower`=0, `sel_upper`=0, `xlat_fault`=1 and `ns_attr`=1.
- R2: With a clamped lower size N, `sel_lower` is 1 exactly when bits 63 down to N of the address are all zero.
- R3: With a clamped upper size N, `sel_upper` is 1 exactly when bits 63 down to N of the address are all one and `priv_lvl` is 0 or 1.
- R4: Each 7-bit size field is clamped before use. A value above 48 counts as 48, and a value below 25 counts as 25.
- R5: `xlat_fault` is 1 exactly when neither select is 1. This covers every address outside both regions.
- R6: At `priv_lvl` 2 or 3 the top region is disabled, so any address outside the bottom region faults.
- R7: When `is_secure`=0, `ns_attr` is 1. When `is_secure`=1, `ns_attr` equals `desc_ns`.
- R8: Exactly one of `sel_lower`, `sel_upper` and `xlat_fault` is 1 in every cycle. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 64 | Virtual address to classify |
| priv_lvl | input | 2 | Current privilege level, 0 (least) to 3 (most) |
| lo_size | input | 7 | Address bits covered by the bottom region |
| hi_size | input | 7 | Address bits covered by the top region |
| is_secure | input | 1 | 1 when the current state is secure |
| desc_ns | input | 1 | Requested non-secure attribute, used only in the secure state |
| sel_lower | output | 1 | Use the lower table base |
| sel_upper | output | 1 | Use the upper table base |
| xlat_fault | output | 1 | The address is in neither region |
| ns_attr | output | 1 | Non-secure attribute for the physical access |

## Verification
A wrong region mask or a wrong clamp shows up at the ports on the first address that sits right at a region edge: the last covered address, the first uncovered address, or the start of the top region. The error appears one cycle after that address is presented. For this reason the bench sweeps those edge addresses for in-range sizes, for oversized and undersized fields, and at all four privilege levels. A broken level gate or security override is visible in the very next registered result. The one-hot relation between the three selects exposes any corrupted result register in the same cycle.

// File: rtl/vaddr_cls_pkg.sv
package vaddr_cls_pkg;
    localparam int VA_W   = 64;
    localparam int SZ_W   = 7;
    localparam int MAX_SZ = 48;
    localparam int MIN_SZ = 25;
    localparam int LVL_W  = 2;

    typedef enum logic [1:0] {
        HIT_LOWER = 2'd0,
        HIT_UPPER = 2'd1,
        HIT_NONE  = 2'd2
    } region_e;

    typedef struct packed {
        region_e region;
        logic    ns;
    } cls_result_t;

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] raw);
        if (raw > SZ_W'(MAX_SZ))      return SZ_W'(MAX_SZ);
        else if (raw < SZ_W'(MIN_SZ)) return SZ_W'(MIN_SZ);
        else                          return raw;
    endfunction
endpackage

// File: rtl/vaddr_size_clamp.sv
module vaddr_size_clamp
    import vaddr_cls_pkg::*;
(
    input  logic [SZ_W-1:0] raw_size,
    output logic [SZ_W-1:0] eff_size
);
    always_comb eff_size = clamp_size(raw_size);
endmodule

// File: rtl/vaddr_region_match.sv
module vaddr_region_match
    import vaddr_cls_pkg::*;
#(
    parameter bit TOP_REGION = 1'b0
)(
    input  logic [VA_W-1:0] vaddr,
    input  logic [SZ_W-1:0] eff_size,
    output logic            hit
);
    logic [VA_W-1:0] hi_mask;

    for (genvar b = 0; b < VA_W; b++) begin : g_mask
        assign hi_mask[b] = (SZ_W'(b) >= eff_size);
    end

    if (TOP_REGION) begin : g_top
        assign hit = ((vaddr & hi_mask) == hi_mask);
    end else begin : g_bot
        assign hit = ((vaddr & hi_mask) == '0);
    end
endmodule

// File: rtl/vaddr_region_cls.sv
module vaddr_region_cls
    import vaddr_cls_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] priv_lvl,
    input  logic [SZ_W-1:0]  lo_size,
    input  logic [SZ_W-1:0]  hi_size,
    input  logic             is_secure,
    input  logic             desc_ns,
    output logic             sel_lower,
    output logic             sel_upper,
    output logic             xlat_fault,
    output logic             ns_attr
);
    logic [SZ_W-1:0] lo_eff, hi_eff;
    logic            lo_hit, hi_hit, top_allowed;
    cls_result_t     nxt, cur;

    vaddr_size_clamp u_lo_clamp (.raw_size(lo_size), .eff_size(lo_eff));
    vaddr_size_clamp u_hi_clamp (.raw_size(hi_size), .eff_size(hi_eff));

    vaddr_region_match #(.TOP_REGION(1'b0)) u_lo_match (
        .vaddr(vaddr), .eff_size(lo_eff), .hit(lo_hit));
    vaddr_region_match #(.TOP_REGION(1'b1)) u_hi_match (
        .vaddr(vaddr), .eff_size(hi_eff), .hit(hi_hit));

    // Only the two least privileged levels own a top region.
    assign top_allowed = (priv_lvl < LVL_W'(2));

    always_comb begin
        if (lo_hit)                    nxt.region = HIT_LOWER;
        else if (hi_hit && top_allowed) nxt.region = HIT_UPPER;
        else                           nxt.region = HIT_NONE;
        nxt.ns = !is_secure || desc_ns;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.region <= HIT_NONE;
            cur.ns     <= 1'b1;
        end else begin
            cur <= nxt;
        end
    end

    assign sel_lower  = (cur.region == HIT_LOWER);
    assign sel_upper  = (cur.region == HIT_UPPER);
    assign xlat_fault = (cur.region == HIT_NONE);
    assign ns_attr    = cur.ns;
endmodule

// File: rtl/vaddr_region_cls_chk.sv
module vaddr_region_cls_chk (
    input logic        clk,
    input logic        rst,
    input logic [63:0] vaddr,
    input logic [1:0]  priv_lvl,
    input logic        is_secure,
    input logic        sel_lower,
    input logic        sel_upper,
    input logic        xlat_fault,
    input logic        ns_attr
);
    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_lower, sel_upper, xlat_fault}) == 1);

    // R6
    no_top_high_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(priv_lvl) >= 2'd2) |-> !sel_upper);

    // R7
    ns_forced_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(is_secure)) |-> ns_attr);

    // R5
    gap_fault_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(vaddr[63:48]) != 16'h0000
                     && $past(vaddr[63:48]) != 16'hFFFF) |-> xlat_fault);

    // R4
    min_lower_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(vaddr[63:25]) == '0) |-> sel_lower);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (xlat_fault && ns_attr && !sel_lower && !sel_upper));
endmodule

bind vaddr_region_cls vaddr_region_cls_chk u_chk (
    .clk(clk), .rst(rst), .vaddr(vaddr), .priv_lvl(priv_lvl),
    .is_secure(is_secure), .sel_lower(sel_lower), .sel_upper(sel_upper),
    .xlat_fault(xlat_fault), .ns_attr(ns_attr));

// File: tb/vaddr_region_cls_bench.sv
module vaddr_region_cls_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] vaddr = '0;
    logic [1:0]  priv_lvl = '0;
    logic [6:0]  lo_size = 7'd48;
    logic [6:0]  hi_size = 7'd48;
    logic        is_secure = 1'b0;
    logic        desc_ns = 1'b0;
    logic        sel_lower, sel_upper, xlat_fault, ns_attr;

    int total = 0;
    int bad   = 0;
    logic [3:0] exp_q[$];

    always #2.5 clk = ~clk;

    vaddr_region_cls u_vaddr_region_cls (
        .clk(clk), .rst(rst), .vaddr(vaddr), .priv_lvl(priv_lvl),
        .lo_size(lo_size), .hi_size(hi_size), .is_secure(is_secure),
        .desc_ns(desc_ns), .sel_lower(sel_lower), .sel_upper(sel_upper),
        .xlat_fault(xlat_fault), .ns_attr(ns_attr));

    function automatic int eff(input int raw);
        if (raw > 48) return 48;
        if (raw < 25) return 25;
        return raw;
    endfunction

    // Expected {lower, upper, fault, ns}
    function automatic logic [3:0] model(input logic [63:0] a, input int lvl,
                                         input int lsz, input int hsz,
                                         input logic sec, input logic dns);
        logic lo, hi;
        lo = ((a >> eff(lsz)) == 64'd0);
        hi = !lo && (lvl < 2) && (((~a) >> eff(hsz)) == 64'd0);
        return {lo, hi, !(lo || hi), (!sec) | dns};
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] a, input int lvl, input int lsz,
                         input int hsz, input logic sec, input logic dns);
        logic [3:0] e;
        vaddr = a; priv_lvl = 2'(lvl); lo_size = 7'(lsz); hi_size = 7'(hsz);
        is_secure = sec; desc_ns = dns;
        exp_q.push_back(model(a, lvl, lsz, hsz, sec, dns));
        @(posedge clk); #1;
        e = exp_q.pop_front();
        check("R2 R4 sel_lower", sel_lower, e[3]);
        check("R3 R6 sel_upper", sel_upper, e[2]);
        check("R5 xlat_fault", xlat_fault, e[1]);
        check("R7 ns_attr", ns_attr, e[0]);
        check("R8 one-hot", logic'($countones({sel_lower, sel_upper, xlat_fault}) == 1), 1'b1);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sizes[7] = '{25, 30, 39, 42, 48, 60, 10};
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 sel_lower", sel_lower, 1'b0);
        check("R1 sel_upper", sel_upper, 1'b0);
        check("R1 xlat_fault", xlat_fault, 1'b1);
        check("R1 ns_attr", ns_attr, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        foreach (sizes[i]) begin
            for (int lvl = 0; lvl < 4; lvl++) begin
                int n;
                logic [63:0] edge_lo, top_start;
                n = eff(sizes[i]);
                edge_lo   = (64'd1 << n) - 64'd1;
                top_start = ~64'd0 << n;
                apply(64'd0,              lvl, sizes[i], sizes[i], 1'b0, 1'b0);
                apply(edge_lo,            lvl, sizes[i], 48,       1'b1, 1'b0);
                apply(edge_lo + 64'd1,    lvl, sizes[i], 48,       1'b1, 1'b1);
                apply(~64'd0,             lvl, 48, sizes[i],       1'b0, 1'b1);
                apply(top_start,          lvl, 48, sizes[i],       1'b1, 1'b0);
                apply(top_start - 64'd1,  lvl, 25, sizes[i],       1'b1, 1'b1);
                apply(64'h8000_0000_0000_0000, lvl, sizes[i], sizes[i], 1'b0, 1'b0);
            end
        end
        // R4: independent sizes, clamped ends
        apply(64'h0000_0100_0000_0000, 0, 127, 0,   1'b1, 1'b0);
        apply(64'hFFFF_FF00_0000_0000, 1, 0,   127, 1'b1, 1'b0);
        apply(64'h0000_0000_0200_0000, 0, 24,  24,  1'b0, 1'b0);
        apply(64'hFFFF_FFFF_FE00_0000, 1, 24,  25,  1'b0, 1'b0);
        // R1 again: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset mid sel_lower", sel_lower, 1'b0);
        check("R1 reset mid xlat_fault", xlat_fault, 1'b1);
        check("R1 reset mid ns_attr", ns_attr, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule